// File: doc/BRIEF.md
# Memory Channel Event and Cycle Counter Unit

This block watches one channel of a memory controller. It counts how often one chosen event occurs, and it also counts clock cycles. Software uses a plain write port and a separate read port. It picks an event code, enables each counter, and sets the counters running. To learn the load on the channel, software loads the event counter with a value close to its top. The counter then wraps after a known number of events. The wrap sets an overflow flag, and the flag can raise an interrupt. Comparing the time between interrupts gives a measure of memory pressure without polling.

The controller decodes its events elsewhere. They arrive here as a vector with one pulse line per 8-bit event code. The register at offset 0xE000 is the run control. Bit 0 of the register at 0x0130 opens the local count clock. The enable, interrupt-enable and flag words use bit 2 for the event counter and bit 31 for the cycle counter.

Top module: `perfmon_unit`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low.
- R2: No counter advances while bit 0 of the count-clock register (0x0130) is 0. Writing bit 0 changes the gate from the next cycle on.
- R3: Bit 0 of the run-control register (0xE000) starts all enabled counters. Writing 0 stops them. The register reads back bit 0 only.
- R4: Writing the run-control register with bit 1 set clears the event counter in that cycle. Bit 2 clears the cycle counter the same way. Both bits read back as 0.
- R5: A 1 written to the enable-set register (0xE010) sets the matching enable bit. A 1 written to the enable-clear register (0xE020) clears it. The interrupt-enable set and clear registers (0xE030, 0xE040) work the same way. Bits written as 0 keep their value. Both addresses of a pair read back the current mask. Bit 2 is the event counter and bit 31 is the cycle counter.
- R6: The event-select register (0x013C) holds an 8-bit code, for example 0x6D or 0x6F. Only the pulse line with that index advances the event counter.
- R7: The cycle counter (read at 0xE100) advances by one in each cycle in which the gate is open, the unit is running and bit 31 is enabled.
- R8: The event counter (0xE130) can be written. A written value P wraps after 2^32−P counted events. If a write and a counted event fall in the same cycle, the written value is kept.
- R9: When a counter wraps from 0xFFFFFFFF to 0, its flag bit in 0xE050 is set. If the flag is written clear in the same cycle as a wrap, the flag stays set.
- R10: Writing a 1 to a bit of the flag register clears that flag. Writing a 0 leaves the flag unchanged.
- R11: `irq` is high whenever some flag bit and the matching interrupt-enable bit are both 1. It stays high until the flag or the enable bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 16 | Read byte offset |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| evt_pulse | input | 256 | One pulse line per event code |
| irq | output | 1 | Level interrupt |

## Verification
Two pairs of actions can land in the same cycle. A preload write to the event counter can coincide with a pulse on the selected event line. A write-one-to-clear of the overflow flag can coincide with the wrap of that counter. The bench builds both cases on purpose. It preloads while the selected line pulses, and it clears the flag in the exact cycle the counter steps past 0xFFFFFFFF. The results are judged against R8 and R9: the written value must stand, and the flag must remain set. Random traffic then mixes preloads near the top of the count with flag writes, so that such collisions also happen unplanned. A reference model in the bench checks every cycle.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;

   localparam logic [15:0] OFS_CLKGATE = 16'h0130;
   localparam logic [15:0] OFS_EVSEL   = 16'h013C;
   localparam logic [15:0] OFS_CTRL    = 16'hE000;
   localparam logic [15:0] OFS_EN_SET  = 16'hE010;
   localparam logic [15:0] OFS_EN_CLR  = 16'hE020;
   localparam logic [15:0] OFS_IE_SET  = 16'hE030;
   localparam logic [15:0] OFS_IE_CLR  = 16'hE040;
   localparam logic [15:0] OFS_FLAG    = 16'hE050;
   localparam logic [15:0] OFS_CYCCNT  = 16'hE100;
   localparam logic [15:0] OFS_EVCNT   = 16'hE130;

   localparam int unsigned BIT_EV    = 2;
   localparam int unsigned BIT_CYC   = 31;
   localparam int unsigned CTRL_RUN  = 0;
   localparam int unsigned CTRL_EVRS = 1;
   localparam int unsigned CTRL_CYRS = 2;

   typedef struct packed {
      logic cyc;
      logic ev;
   } ctr_mask_t;

endpackage

// File: rtl/perfmon_counter.sv
module perfmon_counter #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         clr,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   output logic [W-1:0] cnt,
   output logic         wrap
);

   localparam logic [W-1:0] ONE = W'(1);

   initial begin
      assert (W >= 2) else $error("perfmon_counter: W too small");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (ld)    cnt <= ld_val;
      else if (clr)   cnt <= '0;
      else if (inc)   cnt <= cnt + ONE;
   end

   assign wrap = inc & ~ld & ~clr & (&cnt);

   // R8
   ld_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> cnt == $past(ld_val));

   // R4
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !ld) |=> cnt == '0);

   // R7
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !ld && !clr) |=> cnt == $past(cnt) + ONE);

   // R2
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !ld && !clr) |=> $stable(cnt));

endmodule

// File: rtl/perfmon_evsel.sv
module perfmon_evsel #(
   parameter int unsigned SEL_W = 8,
   localparam int unsigned NUM_EVT = 1 << SEL_W
) (
   input  logic [NUM_EVT-1:0] evt,
   input  logic [SEL_W-1:0]   sel,
   output logic               hit
);

   initial begin
      assert (SEL_W >= 1 && SEL_W <= 10) else $error("perfmon_evsel: SEL_W out of range");
   end

   assign hit = evt[sel];

endmodule

// File: rtl/perfmon_regs.sv
module perfmon_regs
   import perfmon_pkg::*;
#(
   parameter int unsigned ADDR_W       = 16,
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned SEL_W        = 8,
   parameter int unsigned CNT_W        = 32,
   parameter bit          CYC_WRITABLE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic [CNT_W-1:0]  ev_cnt,
   input  logic [CNT_W-1:0]  cy_cnt,
   input  logic              ev_wrap,
   input  logic              cy_wrap,
   output logic              clk_on,
   output logic              run,
   output logic [SEL_W-1:0]  ev_sel,
   output ctr_mask_t         cnt_en,
   output logic              ev_ld,
   output logic              ev_clr,
   output logic              cy_ld,
   output logic              cy_clr,
   output logic              irq
);

   ctr_mask_t int_en, flag, wmask, wraps;

   initial begin
      assert (DATA_W >= 32 && CNT_W <= DATA_W && SEL_W <= DATA_W && ADDR_W == 16)
         else $error("perfmon_regs: bad width parameters");
   end

   function automatic logic hit(input logic [15:0] ofs);
      return wr_en && (wr_addr == ADDR_W'(ofs));
   endfunction

   function automatic logic [DATA_W-1:0] place(input ctr_mask_t m);
      logic [DATA_W-1:0] v;
      v          = '0;
      v[BIT_EV]  = m.ev;
      v[BIT_CYC] = m.cyc;
      return v;
   endfunction

   assign wmask.ev  = wr_data[BIT_EV];
   assign wmask.cyc = wr_data[BIT_CYC];
   assign wraps.ev  = ev_wrap;
   assign wraps.cyc = cy_wrap;

   assign ev_ld  = hit(OFS_EVCNT);
   assign ev_clr = hit(OFS_CTRL) && wr_data[CTRL_EVRS];
   assign cy_clr = hit(OFS_CTRL) && wr_data[CTRL_CYRS];

   generate
      if (CYC_WRITABLE) begin : g_cyc_wr
         assign cy_ld = hit(OFS_CYCCNT);
      end else begin : g_cyc_ro
         assign cy_ld = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_on <= 1'b0;
         run    <= 1'b0;
         ev_sel <= '0;
         cnt_en <= '0;
         int_en <= '0;
         flag   <= '0;
      end else begin
         if (hit(OFS_CLKGATE)) clk_on <= wr_data[0];
         if (hit(OFS_EVSEL))   ev_sel <= wr_data[SEL_W-1:0];
         if (hit(OFS_CTRL))    run    <= wr_data[CTRL_RUN];
         if (hit(OFS_EN_SET))  cnt_en <= cnt_en | wmask;
         if (hit(OFS_EN_CLR))  cnt_en <= cnt_en & ~wmask;
         if (hit(OFS_IE_SET))  int_en <= int_en | wmask;
         if (hit(OFS_IE_CLR))  int_en <= int_en & ~wmask;
         if (hit(OFS_FLAG))    flag   <= (flag & ~wmask) | wraps;
         else                  flag   <= flag | wraps;
      end
   end

   assign irq = |(flag & int_en);

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         ADDR_W'(OFS_CLKGATE): rd_data[0]         = clk_on;
         ADDR_W'(OFS_EVSEL):   rd_data[SEL_W-1:0] = ev_sel;
         ADDR_W'(OFS_CTRL):    rd_data[CTRL_RUN]  = run;
         ADDR_W'(OFS_EN_SET),
         ADDR_W'(OFS_EN_CLR):  rd_data = place(cnt_en);
         ADDR_W'(OFS_IE_SET),
         ADDR_W'(OFS_IE_CLR):  rd_data = place(int_en);
         ADDR_W'(OFS_FLAG):    rd_data = place(flag);
         ADDR_W'(OFS_CYCCNT):  rd_data = DATA_W'(cy_cnt);
         ADDR_W'(OFS_EVCNT):   rd_data = DATA_W'(ev_cnt);
         default:              rd_data = '0;
      endcase
   end

   // R9
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_wrap |=> flag.ev);

   // R10
   flag_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit(OFS_FLAG) && wr_data[BIT_EV] && !ev_wrap) |=> !flag.ev);

   // R5
   en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit(OFS_EN_SET) && wr_data[BIT_EV]) |=> cnt_en.ev);

endmodule

// File: rtl/perfmon_unit.sv
module perfmon_unit
   import perfmon_pkg::*;
#(
   parameter int unsigned ADDR_W       = 16,
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned SEL_W        = 8,
   parameter int unsigned CNT_W        = 32,
   parameter bit          CYC_WRITABLE = 1'b0,
   localparam int unsigned NUM_EVT     = 1 << SEL_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [DATA_W-1:0]  rd_data,
   input  logic [NUM_EVT-1:0] evt_pulse,
   output logic               irq
);

   logic             clk_on, run, go, ev_hit;
   logic [SEL_W-1:0] ev_sel;
   ctr_mask_t        cnt_en;
   logic             ev_ld, ev_clr, cy_ld, cy_clr;
   logic             ev_inc, cy_inc, ev_wrap, cy_wrap;
   logic [CNT_W-1:0] ev_cnt, cy_cnt;

   perfmon_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W),
      .CNT_W(CNT_W), .CYC_WRITABLE(CYC_WRITABLE)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .ev_cnt(ev_cnt), .cy_cnt(cy_cnt),
      .ev_wrap(ev_wrap), .cy_wrap(cy_wrap),
      .clk_on(clk_on), .run(run), .ev_sel(ev_sel), .cnt_en(cnt_en),
      .ev_ld(ev_ld), .ev_clr(ev_clr), .cy_ld(cy_ld), .cy_clr(cy_clr),
      .irq(irq)
   );

   perfmon_evsel #(.SEL_W(SEL_W)) u_evsel (
      .evt(evt_pulse), .sel(ev_sel), .hit(ev_hit)
   );

   assign go     = clk_on & run;
   assign ev_inc = go & cnt_en.ev & ev_hit;
   assign cy_inc = go & cnt_en.cyc;

   perfmon_counter #(.W(CNT_W)) u_evcnt (
      .clk(clk), .rst_n(rst_n), .inc(ev_inc), .clr(ev_clr),
      .ld(ev_ld), .ld_val(wr_data[CNT_W-1:0]),
      .cnt(ev_cnt), .wrap(ev_wrap)
   );

   perfmon_counter #(.W(CNT_W)) u_cycnt (
      .clk(clk), .rst_n(rst_n), .inc(cy_inc), .clr(cy_clr),
      .ld(cy_ld), .ld_val(wr_data[CNT_W-1:0]),
      .cnt(cy_cnt), .wrap(cy_wrap)
   );

   // R2
   gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_on && !ev_ld && !ev_clr) |=> $stable(ev_cnt));

   // R3
   stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !cy_ld && !cy_clr) |=> $stable(cy_cnt));

   // R11
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !(wr_en && (wr_addr == ADDR_W'(OFS_FLAG) || wr_addr == ADDR_W'(OFS_IE_CLR))))
      |=> irq);

endmodule

// File: tb/tb_perfmon_unit.sv
module tb_perfmon_unit;
   import perfmon_pkg::*;
   timeunit 1ns;
   timeprecision 100ps;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         wr_en;
   logic [15:0]  wr_addr, rd_addr;
   logic [31:0]  wr_data, rd_data;
   logic [255:0] evt_pulse;
   logic         irq;

   always #2 clk = ~clk;

   perfmon_unit dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .evt_pulse(evt_pulse), .irq(irq)
   );

   // reference model: index 0 = event counter, index 1 = cycle counter
   logic        m_clk, m_run;
   logic [7:0]  m_sel;
   logic [1:0]  m_en, m_ie, m_fl;
   logic [31:0] m_ev, m_cy;
   int checks = 0, fails = 0;
   bit finished = 0;

   function automatic logic [31:0] word_of(input logic [1:0] m);
      logic [31:0] v = '0;
      v[2]  = m[0];
      v[31] = m[1];
      return v;
   endfunction

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
      end
   endtask

   task automatic peek(input logic [15:0] a, output logic [31:0] v);
      rd_addr = a;
      #0.1;
      v = rd_data;
   endtask

   task automatic check_all(input string tag);
      logic [31:0] v;
      peek(OFS_EVCNT, v);  chk(tag, "evcnt", v, m_ev);
      peek(OFS_CYCCNT, v); chk(tag, "cyccnt", v, m_cy);
      peek(OFS_FLAG, v);   chk(tag, "flag", v, word_of(m_fl));
      peek(OFS_EN_SET, v); chk(tag, "enable", v, word_of(m_en));
      chk(tag, "irq", {31'd0, irq}, {31'd0, |(m_fl & m_ie)});
   endtask

   task automatic step(input logic w, input logic [15:0] a, input logic [31:0] d, input logic [255:0] e);
      logic go, ev_inc, cy_inc;
      logic [1:0] wm, n_fl, n_en, n_ie, setf;
      logic [31:0] n_ev, n_cy;
      logic n_clk, n_run;
      logic [7:0] n_sel;
      @(negedge clk);
      wr_en = w; wr_addr = a; wr_data = d; evt_pulse = e;
      go     = m_clk & m_run;
      ev_inc = go & m_en[0] & e[m_sel];
      cy_inc = go & m_en[1];
      wm     = {d[31], d[2]};
      setf   = 2'b00;
      n_ev = m_ev; n_cy = m_cy; n_fl = m_fl; n_en = m_en; n_ie = m_ie;
      n_clk = m_clk; n_run = m_run; n_sel = m_sel;
      if (w && a == OFS_EVCNT) n_ev = d;
      else if (w && a == OFS_CTRL && d[1]) n_ev = '0;
      else if (ev_inc) begin
         if (m_ev == 32'hFFFF_FFFF) setf[0] = 1'b1;
         n_ev = m_ev + 32'd1;
      end
      if (w && a == OFS_CTRL && d[2]) n_cy = '0;
      else if (cy_inc) begin
         if (m_cy == 32'hFFFF_FFFF) setf[1] = 1'b1;
         n_cy = m_cy + 32'd1;
      end
      if (w && a == OFS_FLAG) n_fl = n_fl & ~wm;
      n_fl = n_fl | setf;
      if (w && a == OFS_EN_SET)  n_en = m_en | wm;
      if (w && a == OFS_EN_CLR)  n_en = m_en & ~wm;
      if (w && a == OFS_IE_SET)  n_ie = m_ie | wm;
      if (w && a == OFS_IE_CLR)  n_ie = m_ie & ~wm;
      if (w && a == OFS_CLKGATE) n_clk = d[0];
      if (w && a == OFS_EVSEL)   n_sel = d[7:0];
      if (w && a == OFS_CTRL)    n_run = d[0];
      @(posedge clk);
      #1;
      m_ev = n_ev; m_cy = n_cy; m_fl = n_fl; m_en = n_en; m_ie = n_ie;
      m_clk = n_clk; m_run = n_run; m_sel = n_sel;
      wr_en = 1'b0; evt_pulse = '0;
   endtask

   task automatic wr(input logic [15:0] a, input logic [31:0] d);
      step(1'b1, a, d, '0);
   endtask

   function automatic logic [255:0] one_evt(input int idx);
      logic [255:0] e = '0;
      e[idx] = 1'b1;
      return e;
   endfunction

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(4 * 200000);
      fails++;
      $display("FAIL watchdog expired act=running exp=done");
      finish_run();
   end

   localparam logic [15:0] ADDRS [10] = '{OFS_CLKGATE, OFS_EVSEL, OFS_CTRL, OFS_EN_SET, OFS_EN_CLR,
                                          OFS_IE_SET, OFS_IE_CLR, OFS_FLAG, OFS_CYCCNT, OFS_EVCNT};

   initial begin
      logic [31:0] v;
      void'($urandom(32'd20190925));
      rst_n = 1'b0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0; evt_pulse = '0;
      m_clk = 0; m_run = 0; m_sel = 0; m_en = 0; m_ie = 0; m_fl = 0; m_ev = 0; m_cy = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      for (int i = 0; i < 10; i++) begin
         peek(ADDRS[i], v);
         chk("R1", "reset reg", v, 32'd0);
      end
      chk("R1", "reset irq", {31'd0, irq}, 32'd0);

      // R5, R6, R7: set up and count selected code
      wr(OFS_CLKGATE, 32'd1);
      wr(OFS_EVSEL, 32'h6D);
      wr(OFS_EN_SET, 32'h8000_0004);
      wr(OFS_CTRL, 32'd1);
      peek(OFS_CTRL, v); chk("R3", "ctrl readback", v, 32'd1);
      for (int i = 0; i < 5; i++) step(1'b0, 16'h0, 32'd0, one_evt(8'h6D));
      peek(OFS_EVCNT, v); chk("R6", "count 0x6D", v, 32'd5);
      check_all("R7");

      // R6: other code ignored
      for (int i = 0; i < 4; i++) step(1'b0, 16'h0, 32'd0, one_evt(8'h6F));
      peek(OFS_EVCNT, v); chk("R6", "0x6F ignored", v, 32'd5);
      wr(OFS_EVSEL, 32'h6F);
      step(1'b0, 16'h0, 32'd0, one_evt(8'h6F));
      peek(OFS_EVCNT, v); chk("R6", "0x6F counted", v, 32'd6);

      // R2: gate closed
      wr(OFS_CLKGATE, 32'd0);
      peek(OFS_CYCCNT, v);
      for (int i = 0; i < 4; i++) step(1'b0, 16'h0, 32'd0, one_evt(8'h6F));
      check_all("R2");
      wr(OFS_CLKGATE, 32'd1);

      // R3: stop
      wr(OFS_CTRL, 32'd0);
      for (int i = 0; i < 3; i++) step(1'b0, 16'h0, 32'd0, one_evt(8'h6F));
      check_all("R3");
      peek(OFS_CTRL, v); chk("R3", "ctrl stopped", v, 32'd0);

      // R4: reset bits
      wr(OFS_CTRL, 32'h7);
      peek(OFS_EVCNT, v); chk("R4", "evcnt cleared", v, 32'd0);
      peek(OFS_CTRL, v);  chk("R4", "reset bits read 0", v, 32'd1);
      check_all("R4");

      // R8, R9, R11: preload near top, wrap, interrupt
      wr(OFS_IE_SET, 32'h4);
      wr(OFS_EVCNT, 32'hFFFF_FFF0);
      for (int i = 0; i < 15; i++) step(1'b0, 16'h0, 32'd0, one_evt(8'h6F));
      peek(OFS_FLAG, v); chk("R8", "no flag at top", v, 32'd0);
      step(1'b0, 16'h0, 32'd0, one_evt(8'h6F));
      peek(OFS_FLAG, v); chk("R9", "wrap flag", v, 32'h4);
      chk("R11", "irq raised", {31'd0, irq}, 32'd1);
      for (int i = 0; i < 3; i++) step(1'b0, 16'h0, 32'd0, '0);
      chk("R11", "irq held", {31'd0, irq}, 32'd1);

      // R10: W1C, zero bits unchanged
      wr(OFS_FLAG, 32'h0);
      peek(OFS_FLAG, v); chk("R10", "zero write keeps", v, 32'h4);
      wr(OFS_FLAG, 32'h4);
      peek(OFS_FLAG, v); chk("R10", "w1c clears", v, 32'h0);
      chk("R11", "irq dropped", {31'd0, irq}, 32'd0);

      // R8: preload against event in same cycle
      step(1'b1, OFS_EVCNT, 32'h1234_5678, one_evt(8'h6F));
      peek(OFS_EVCNT, v); chk("R8", "preload wins", v, 32'h1234_5678);

      // R9: wrap against clear in same cycle
      wr(OFS_EVCNT, 32'hFFFF_FFFF);
      step(1'b1, OFS_FLAG, 32'h4, one_evt(8'h6F));
      peek(OFS_FLAG, v); chk("R9", "wrap beats clear", v, 32'h4);
      check_all("R9");

      // R5: clear set with zero bits
      wr(OFS_EN_CLR, 32'h4);
      peek(OFS_EN_CLR, v); chk("R5", "enable clear", v, 32'h8000_0000);
      wr(OFS_EN_SET, 32'h0);
      peek(OFS_EN_SET, v); chk("R5", "zero set keeps", v, 32'h8000_0000);
      wr(OFS_EN_SET, 32'h4);

      // random phase
      for (int n = 0; n < 3000; n++) begin
         logic w;
         logic [15:0] a;
         logic [31:0] d;
         logic [255:0] e;
         w = ($urandom_range(0, 3) == 0);
         a = ADDRS[$urandom_range(0, 9)];
         d = $urandom;
         if (a == OFS_EVCNT && $urandom_range(0, 1) == 1) d = 32'hFFFF_FFF0 | 32'($urandom_range(0, 15));
         if (a == OFS_CTRL) begin
            d = '0;
            d[0] = ($urandom_range(0, 7) != 0);
            d[1] = ($urandom_range(0, 9) == 0);
            d[2] = ($urandom_range(0, 9) == 0);
         end
         if (a == OFS_CLKGATE) d[0] = ($urandom_range(0, 7) != 0);
         if (a == OFS_EVSEL && $urandom_range(0, 1) == 1) d = ($urandom_range(0, 1) == 1) ? 32'h6D : 32'h6F;
         e = '0;
         if ($urandom_range(0, 1) == 1) e[m_sel] = 1'b1;
         if ($urandom_range(0, 3) == 0) e[$urandom_range(0, 255)] = 1'b1;
         step(w, a, d, e);
         check_all("rand");
      end

      finish_run();
   end

endmodule